// File: doc/BRIEF.md
# Class-Mask Frame Router

This block steers each received frame to one of several output ports. It sits after a packet filter in a network endpoint. With every frame the filter sends an 8-bit class field and a discard flag. The class field is a bitmask, so any number of its bits may be set at once. Frames move as a byte stream with a valid/ready handshake, a start marker and an end marker. The class field and the discard flag are read on the first beat of a frame.

Each output port except the last has a run-time class mask. Ports are tested from the lowest number upward, and the frame goes to the first port whose mask shares at least one bit with the frame's class field. A frame that matches none of them goes to the last port, which therefore needs no mask of its own. With two ports, a mask of 0x0F on port 0 sends the low four class bits to the CPU side and everything else to the fabric side. This is the same as a 0x0F / 0xF0 split.

The decision is made on the first beat and then held until the end beat has been accepted. The whole frame therefore reaches one port, and mask changes take effect only at the next frame. The chosen port receives the full class field with every beat. A discarded frame is swallowed at full rate and is never stalled. Backpressure comes only from the port that was chosen.

Top module: `frame_class_router`

## Requirements
- R1: A frame whose discard flag is 1 on its first beat produces no output beat on any port, whatever its class field holds.
- R2: A frame that is not discarded goes to the lowest-numbered port p (p below NUM_PORTS-1) whose mask ANDed with the class field is non-zero. Bit p*8 of `port_mask_i` is bit 0 of port p's mask. When several masks match, the lowest port wins, whatever class bit matched.
- R3: A frame whose class field matches no mask goes to port NUM_PORTS-1. This includes a class field of zero.
- R4: The chosen port's `out_class` slice shows the full class field taken on the first beat, on every beat of the frame, with all of its set bits.
- R5: The masks and the input class and discard values are only read on the first beat. Changing them on later beats does not change where the frame goes.
- R6: Every beat of a forwarded frame appears once, in order, on the chosen port, with data, start and end markers unchanged.
- R7: While a discarded frame is in progress, `in_ready` is 1 on every beat up to and including its end beat.
- R8: At most one `out_valid` bit is 1 at a time. During a forwarded frame, `in_ready` equals the chosen port's `out_ready`.
- R9: While reset is high, and afterwards while no input is valid, `in_ready` is 0 and every `out_valid` bit is 0.
- R10: A single-beat frame (start and end on the same beat) is routed or discarded by itself. The next beat begins a new frame with a new decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_mask_i | input | (NUM_PORTS-1)*8 | Class masks of ports 0 to NUM_PORTS-2, port p in bits p*8+7:p*8 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input beat data |
| in_sof | input | 1 | First beat of frame |
| in_eof | input | 1 | Last beat of frame |
| in_class | input | 8 | Class bitmask, read on first beat |
| in_drop | input | 1 | Discard flag, read on first beat |
| out_valid | output | NUM_PORTS | Per-port beat valid |
| out_ready | input | NUM_PORTS | Per-port ready |
| out_data | output | NUM_PORTS*DATA_W | Per-port data, port p in slice p |
| out_sof | output | NUM_PORTS | Per-port first-beat marker |
| out_eof | output | NUM_PORTS | Per-port last-beat marker |
| out_class | output | NUM_PORTS*8 | Per-port class field of the current frame |

## Verification
Some properties are checked on every cycle against a frame tracker that is separate from the design. These are: a discarded frame stays silent and is drained without stalls, at most one port is valid, the port stays fixed for the whole frame, input ready follows the chosen port's ready, and the first beat goes to the port that mask priority picks. Other behaviour can only be shown by the bench scenarios, which compare every output beat with a queue-based model under random backpressure. These are: whole frames arrive complete and in order on the right port, the class field is carried on every beat, and a mask change in the middle of a frame has no effect.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int CLASS_W   = 8;
    localparam int MAX_PORTS = 4;
    localparam int PORT_W    = $clog2(MAX_PORTS);

    typedef logic [CLASS_W-1:0] class_t;
    typedef logic [PORT_W-1:0]  port_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_DRAIN = 2'd2
    } fsm_t;

    typedef struct packed {
        port_t  port;
        class_t cls;
    } route_t;

    function automatic logic class_hit(input class_t mask, input class_t cls);
        return |(mask & cls);
    endfunction

endpackage

// File: rtl/fcr_port_select.sv
module fcr_port_select
    import fcr_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  class_t masks [NUM_PORTS-1],
    input  class_t cls,
    output port_t  pick
);

    localparam int NUM_MASKED = NUM_PORTS - 1;

    logic [NUM_MASKED-1:0] hit;

    for (genvar g = 0; g < NUM_MASKED; g++) begin : g_hit
        assign hit[g] = class_hit(masks[g], cls);
    end

    // The last port takes every frame that no earlier port claims.
    always_comb begin
        pick = port_t'(NUM_PORTS - 1);
        for (int p = NUM_MASKED - 1; p >= 0; p--) begin
            if (hit[p]) pick = port_t'(p);
        end
    end

endmodule

// File: rtl/fcr_frame_ctrl.sv
module fcr_frame_ctrl
    import fcr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   in_eof,
    input  logic   in_drop,
    input  class_t in_class,
    input  port_t  pick,
    input  logic   sel_ready,
    output logic   in_ready,
    output logic   pass,
    output route_t route
);

    fsm_t   state;
    route_t held;
    logic   at_start;
    logic   take;

    assign at_start = (state == ST_IDLE);

    always_comb begin
        if (at_start) route = '{port: pick, cls: in_class};
        else          route = held;
    end

    assign pass     = (at_start && in_valid && !in_drop) || (state == ST_PASS);
    assign in_ready = (at_start && in_valid && in_drop)
                    || (state == ST_DRAIN)
                    || (pass && sel_ready);
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            held  <= '0;
        end else if (take) begin
            unique case (state)
                ST_IDLE: begin
                    held <= route;
                    if (!in_eof) state <= in_drop ? ST_DRAIN : ST_PASS;
                end
                ST_PASS, ST_DRAIN: begin
                    if (in_eof) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcr_out_steer.sv
module fcr_out_steer
    import fcr_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 8
) (
    input  logic                          pass,
    input  route_t                        route,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    input  logic                          in_sof,
    input  logic                          in_eof,
    input  logic [NUM_PORTS-1:0]          out_ready,
    output logic                          sel_ready,
    output logic [NUM_PORTS-1:0]          out_valid,
    output logic [NUM_PORTS*DATA_W-1:0]   out_data,
    output logic [NUM_PORTS-1:0]          out_sof,
    output logic [NUM_PORTS-1:0]          out_eof,
    output logic [NUM_PORTS*CLASS_W-1:0]  out_class
);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        // Payload fans out to every port; only the valid is steered.
        assign out_valid[g]                  = pass && in_valid && (route.port == port_t'(g));
        assign out_data[g*DATA_W +: DATA_W]  = in_data;
        assign out_sof[g]                    = in_sof;
        assign out_eof[g]                    = in_eof;
        assign out_class[g*CLASS_W +: CLASS_W] = route.cls;
    end

    always_comb begin
        sel_ready = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (route.port == port_t'(p)) sel_ready = out_ready[p];
        end
    end

endmodule

// File: rtl/frame_class_router.sv
module frame_class_router
    import fcr_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [(NUM_PORTS-1)*CLASS_W-1:0]     port_mask_i,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [DATA_W-1:0]                    in_data,
    input  logic                                 in_sof,
    input  logic                                 in_eof,
    input  logic [CLASS_W-1:0]                   in_class,
    input  logic                                 in_drop,
    output logic [NUM_PORTS-1:0]                 out_valid,
    input  logic [NUM_PORTS-1:0]                 out_ready,
    output logic [NUM_PORTS*DATA_W-1:0]          out_data,
    output logic [NUM_PORTS-1:0]                 out_sof,
    output logic [NUM_PORTS-1:0]                 out_eof,
    output logic [NUM_PORTS*CLASS_W-1:0]         out_class
);

    localparam int NUM_MASKED = NUM_PORTS - 1;

    class_t mask_arr [NUM_MASKED];
    port_t  pick;
    route_t route;
    logic   pass;
    logic   sel_ready;

    for (genvar g = 0; g < NUM_MASKED; g++) begin : g_mask
        assign mask_arr[g] = port_mask_i[g*CLASS_W +: CLASS_W];
    end

    fcr_port_select #(.NUM_PORTS(NUM_PORTS)) u_select (
        .masks (mask_arr),
        .cls   (in_class),
        .pick  (pick)
    );

    fcr_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_eof    (in_eof),
        .in_drop   (in_drop),
        .in_class  (in_class),
        .pick      (pick),
        .sel_ready (sel_ready),
        .in_ready  (in_ready),
        .pass      (pass),
        .route     (route)
    );

    fcr_out_steer #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_steer (
        .pass      (pass),
        .route     (route),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .out_ready (out_ready),
        .sel_ready (sel_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_class (out_class)
    );

endmodule

// File: rtl/fcr_router_chk.sv
module fcr_router_chk
    import fcr_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 8
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic [(NUM_PORTS-1)*CLASS_W-1:0]     port_mask_i,
    input logic                                 in_valid,
    input logic                                 in_ready,
    input logic [DATA_W-1:0]                    in_data,
    input logic                                 in_sof,
    input logic                                 in_eof,
    input logic [CLASS_W-1:0]                   in_class,
    input logic                                 in_drop,
    input logic [NUM_PORTS-1:0]                 out_valid,
    input logic [NUM_PORTS-1:0]                 out_ready,
    input logic [NUM_PORTS*DATA_W-1:0]          out_data,
    input logic [NUM_PORTS-1:0]                 out_sof,
    input logic [NUM_PORTS-1:0]                 out_eof,
    input logic [NUM_PORTS*CLASS_W-1:0]         out_class
);

    localparam int NUM_MASKED = NUM_PORTS - 1;

    logic                  in_frame;
    logic                  dropping;
    logic [NUM_PORTS-1:0]  held_sel;
    logic                  beat;
    logic                  start;
    logic [NUM_MASKED-1:0] hit;

    assign beat  = in_valid && in_ready;
    assign start = in_valid && !in_frame && !in_drop;

    for (genvar g = 0; g < NUM_MASKED; g++) begin : g_hit
        assign hit[g] = |(port_mask_i[g*CLASS_W +: CLASS_W] & in_class);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            dropping <= 1'b0;
            held_sel <= '0;
        end else if (beat) begin
            if (!in_frame) begin
                in_frame <= !in_eof;
                dropping <= in_drop;
                held_sel <= out_valid;
            end else if (in_eof) begin
                in_frame <= 1'b0;
                dropping <= 1'b0;
            end
        end
    end

    // R1: a discarded frame's first beat is swallowed, nothing comes out
    a_r1_drop_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_frame && in_drop) |-> (out_valid == '0 && in_ready));

    // R7: the rest of a discarded frame drains without stalling
    a_r7_drain_ready: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_frame && dropping) |-> (in_ready && out_valid == '0));

    // R8: never more than one port valid
    a_r8_one_port: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    // R8: input ready mirrors the chosen port's ready
    a_r8_ready_follow: assert property (@(posedge clk) disable iff (rst)
        (out_valid != '0) |-> (in_ready == |(out_valid & out_ready)));

    // R6: once chosen, the port stays the same for the whole frame
    a_r6_port_held: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_frame && !dropping) |-> (out_valid == held_sel));

    // R3: no mask hit sends the first beat to the last port
    a_r3_fall_through: assert property (@(posedge clk) disable iff (rst)
        (start && hit == '0) |-> out_valid[NUM_PORTS-1]);

    for (genvar g = 0; g < NUM_MASKED; g++) begin : g_prio
        // R2: lowest hitting port takes the frame
        a_r2_lowest_hit: assert property (@(posedge clk) disable iff (rst)
            (start && hit[g] && ((hit & NUM_MASKED'((1 << g) - 1)) == '0)) |-> out_valid[g]);
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cls
        // R4: the first beat carries the full class field to the chosen port
        a_r4_class_first: assert property (@(posedge clk) disable iff (rst)
            (start && out_valid[g]) |-> (out_class[g*CLASS_W +: CLASS_W] == in_class));
    end

endmodule

bind frame_class_router fcr_router_chk #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/frame_class_router_test.sv
`timescale 1ns/1ps
module frame_class_router_test;

    localparam int NP = 3;
    localparam int DW = 8;
    localparam int CW = 8;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [(NP-1)*CW-1:0] port_mask_i;
    logic                 in_valid;
    logic                 in_ready;
    logic [DW-1:0]        in_data;
    logic                 in_sof;
    logic                 in_eof;
    logic [CW-1:0]        in_class;
    logic                 in_drop;
    logic [NP-1:0]        out_valid;
    logic [NP-1:0]        out_ready;
    logic [NP*DW-1:0]     out_data;
    logic [NP-1:0]        out_sof;
    logic [NP-1:0]        out_eof;
    logic [NP*CW-1:0]     out_class;

    always #2 clk = ~clk;

    frame_class_router #(.NUM_PORTS(NP), .DATA_W(DW)) uut (.*);

    typedef struct {
        logic [DW-1:0] d;
        logic          s;
        logic          e;
        logic [CW-1:0] c;
    } beat_t;

    beat_t         exp_q [NP][$];
    logic [CW-1:0] mask [NP-1];
    int            checks = 0;
    int            fails  = 0;
    logic [DW-1:0] seq    = 8'h00;
    bit            ready_rand = 1'b0;

    always_comb begin
        for (int p = 0; p < NP-1; p++) port_mask_i[p*CW +: CW] = mask[p];
    end

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int ref_port(input logic [CW-1:0] c);
        for (int p = 0; p < NP-1; p++) begin
            if ((mask[p] & c) != '0) return p;
        end
        return NP-1;
    endfunction

    // Random backpressure on every output port
    initial begin
        out_ready = '1;
        forever begin
            @(posedge clk);
            #1;
            for (int p = 0; p < NP; p++)
                out_ready[p] = ready_rand ? (($urandom % 4) != 0) : 1'b1;
        end
    end

    // Output monitor, compared on every clock against the model queues
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                check($countones(out_valid) <= 1,
                      $sformatf("R8 valid on several ports: act=%b exp=at most one", out_valid));
                for (int p = 0; p < NP; p++) begin
                    if (out_valid[p] && out_ready[p]) begin
                        if (exp_q[p].size() == 0) begin
                            check(1'b0, $sformatf("R6 port %0d unexpected beat act=%h exp=none",
                                                  p, out_data[p*DW +: DW]));
                        end else begin
                            beat_t b;
                            b = exp_q[p].pop_front();
                            check(out_data[p*DW +: DW] == b.d && out_sof[p] == b.s && out_eof[p] == b.e,
                                  $sformatf("R6 port %0d beat act=%h/%b/%b exp=%h/%b/%b", p,
                                            out_data[p*DW +: DW], out_sof[p], out_eof[p], b.d, b.s, b.e));
                            check(out_class[p*CW +: CW] == b.c,
                                  $sformatf("R4 port %0d class act=%h exp=%h", p,
                                            out_class[p*CW +: CW], b.c));
                        end
                    end
                end
            end
        end
    end

    task automatic send_frame(input int len, input logic [CW-1:0] cls,
                              input bit drop, input bit swap_mid);
        int            port;
        logic [CW-1:0] saved [NP-1];
        port = ref_port(cls);
        saved = mask;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = seq;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            // R5: class and discard are junk after the first beat
            in_class = (i == 0) ? cls : ~cls;
            in_drop  = (i == 0) ? drop : !drop;
            if (!drop) exp_q[port].push_back('{d: seq, s: (i == 0), e: (i == len - 1), c: cls});
            seq = seq + 8'd1;
            forever begin
                @(negedge clk);
                if (drop)
                    check(in_ready == 1'b1,
                          $sformatf("R7 drain ready act=%b exp=1", in_ready));
                else
                    check(in_ready == out_ready[port],
                          $sformatf("R8 ready act=%b exp=%b", in_ready, out_ready[port]));
                if (in_ready) break;
            end
            @(posedge clk);
            #1;
            if (i == 0 && swap_mid) begin
                for (int p = 0; p < NP-1; p++) mask[p] = ~mask[p];
            end
            if (($urandom % 3) == 0 && i != len - 1) begin
                in_valid = 1'b0;
                @(posedge clk);
                #1;
            end
        end
        in_valid = 1'b0;
        mask = saved;
    endtask

    task automatic run_test();
        in_valid = 1'b0;
        in_data  = '0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        in_class = '0;
        in_drop  = 1'b0;
        mask[0]  = 8'h0F;
        mask[1]  = 8'hF0;
        rst      = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(in_ready == 1'b0 && out_valid == '0,
              $sformatf("R9 in reset act=%b/%b exp=0/0", in_ready, out_valid));
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b0 && out_valid == '0,
              $sformatf("R9 idle act=%b/%b exp=0/0", in_ready, out_valid));
        @(posedge clk);
        #1;

        // R2: single bit and multi bit classes under masks 0F / F0
        send_frame(4, 8'h01, 1'b0, 1'b0);
        send_frame(3, 8'h80, 1'b0, 1'b0);
        send_frame(5, 8'h11, 1'b0, 1'b0);
        send_frame(2, 8'h30, 1'b0, 1'b0);
        // R3: zero class goes to the last port
        send_frame(3, 8'h00, 1'b0, 1'b0);
        // R1 / R7: discarded frames, class set or not
        send_frame(4, 8'h01, 1'b1, 1'b0);
        send_frame(3, 8'h00, 1'b1, 1'b0);
        // R10: single-beat frames, forwarded and discarded
        send_frame(1, 8'h04, 1'b0, 1'b0);
        send_frame(1, 8'h40, 1'b1, 1'b0);
        send_frame(1, 8'h40, 1'b0, 1'b0);

        // R2 with overlapping masks: port order decides, not bit order
        mask[0] = 8'h30;
        mask[1] = 8'h11;
        send_frame(3, 8'h10, 1'b0, 1'b0);
        send_frame(3, 8'h01, 1'b0, 1'b0);
        send_frame(2, 8'h80, 1'b0, 1'b0);
        send_frame(2, 8'hFF, 1'b0, 1'b0);

        // R5: masks inverted after the first beat must not move the frame
        mask[0] = 8'h0F;
        mask[1] = 8'hF0;
        send_frame(5, 8'h02, 1'b0, 1'b1);
        send_frame(5, 8'h00, 1'b0, 1'b1);

        // Random traffic under backpressure
        ready_rand = 1'b1;
        for (int n = 0; n < 60; n++) begin
            mask[0] = 8'($urandom);
            mask[1] = 8'($urandom);
            send_frame(1 + ($urandom % 6), 8'(($urandom % 2) ? $urandom : 0),
                       ($urandom % 5) == 0, ($urandom % 4) == 0);
        end

        ready_rand = 1'b0;
        repeat (20) @(posedge clk);
        for (int p = 0; p < NP; p++)
            check(exp_q[p].size() == 0,
                  $sformatf("R6 port %0d beats missing act=%0d exp=0", p, exp_q[p].size()));
    endtask

    initial begin
        fork
            run_test();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired act=running exp=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule